// File: doc/BRIEF.md
# Supply-Fail Guard for a Battery-Backed Memory

This block sits between a host and a static memory whose contents must survive loss of the main supply. Each clock it takes a quantized supply level (a code from an external converter). From that code it decides whether the memory may be accessed at all, and whether the array draws power from the main rail or from the backup cell. While the supply is healthy, the host's active-low chip, write and output enables reach the memory one register stage later. While the supply is out of tolerance, every host control is ignored, the memory sees all enables inactive, and the data drivers stay off.

Three level detectors with hysteresis feed a four-state machine. The detectors cover the full-operation level, the write-lock level and the rail-switch level. The states are NORMAL, PROTECT, BACKUP and RECOVER. When the supply rises back above the full-operation level, the machine does not reopen access straight away. It holds off for a fixed number of cycles, and that count starts again if the supply sags during the hold-off. If the host still has chip enable asserted at the instant the lock engages, a fault flag is raised. The flag stays set until access is granted again.

Top module: `pwr_guard`

## Requirements
- R1: During and after reset, pwr_state reads BACKUP (code 2). sel_backup is 1, mem_ce_n, mem_we_n and mem_oe_n are 1, bus_en is 0 and ce_fault is 0.
- R2: In NORMAL (code 0), mem_ce_n, mem_we_n and mem_oe_n equal the host enables of the previous cycle. bus_en is 1 exactly when the previous cycle had host_ce_n=0, host_oe_n=0 and host_we_n=1.
- R3: Each level detector has hysteresis. It clears when vcode drops below its level and sets again only once vcode reaches level+HYST. A code between the write-lock and full-operation levels leaves NORMAL unchanged.
- R4: In NORMAL, a vcode below WP_LVL moves pwr_state to PROTECT (code 1) two cycles later. In the first cycle of PROTECT, mem_we_n is already 1, which aborts any write in progress.
- R5: In PROTECT, BACKUP and RECOVER, the host enables are ignored: all three mem enables stay 1 and bus_en stays 0.
- R6: From PROTECT, a vcode below SW_LVL enters BACKUP with sel_backup=1. From BACKUP, a vcode at or above SW_LVL+HYST returns to PROTECT with sel_backup=0.
- R7: From PROTECT, a vcode at or above OK_LVL+HYST enters RECOVER (code 3). After REC_CYCLES cycles of counting in RECOVER, the state becomes NORMAL.
- R8: During RECOVER, a vcode below OK_LVL but not below WP_LVL keeps the state in RECOVER and restarts the hold-off count.
- R9: During RECOVER, a vcode below WP_LVL returns the state to PROTECT.
- R10: ce_fault is set when NORMAL turns into PROTECT while host_ce_n is 0 at that edge. It stays 0 when host_ce_n is 1. It is cleared when NORMAL is re-entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcode | input | CODE_W | Quantized supply level |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Qualified chip enable to the memory |
| mem_we_n | output | 1 | Qualified write enable to the memory |
| mem_oe_n | output | 1 | Qualified output enable to the memory |
| bus_en | output | 1 | Data drivers enabled for a read |
| sel_backup | output | 1 | Array powered from the backup source |
| pwr_state | output | 2 | 0 NORMAL, 1 PROTECT, 2 BACKUP, 3 RECOVER |
| ce_fault | output | 1 | Chip enable was active when the lock engaged |

## Verification
The supply code is driven through several patterns:
- A full ramp from zero exercises every threshold in power-up order and the exact length of the hold-off.
- A sag to just below the write-lock level while a write is held tells the same-cycle abort and the fault flag apart from a late gate.
- Codes parked inside each hysteresis band separate a detector with hysteresis from a plain comparator.
- A shallow dip during the hold-off distinguishes a restarting timer from one that only pauses, and a deep dip there checks the fall back to the lock.
- Host enable patterns in NORMAL and in the locked states show pass-through against don't-care behaviour.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BACKUP  = 2'd2,
    ST_RECOVER = 2'd3
  } pstate_t;

  localparam int unsigned N_LEVELS = 3;
  localparam int unsigned IDX_OK = 0;
  localparam int unsigned IDX_WP = 1;
  localparam int unsigned IDX_SW = 2;
endpackage

// File: rtl/pwr_guard_level.sv
module pwr_guard_level #(
  parameter int unsigned CODE_W = 10,
  parameter int unsigned LVL    = 450,
  parameter int unsigned HYST   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              above
);
  localparam logic [CODE_W:0] FALL_AT = (CODE_W+1)'(LVL);
  localparam logic [CODE_W:0] RISE_AT = (CODE_W+1)'(LVL + HYST);

  logic [CODE_W:0] code_x;
  assign code_x = {1'b0, code};

  // Registered flag: drops below LVL, recovers only at LVL+HYST.
  always_ff @(posedge clk) begin
    if (rst) begin
      above <= 1'b0;
    end else if (above && (code_x < FALL_AT)) begin
      above <= 1'b0;
    end else if (!above && (code_x >= RISE_AT)) begin
      above <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
#(
  parameter int unsigned REC_CYCLES = 500000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    ok_f,
  input  logic    wp_f,
  input  logic    sw_f,
  input  logic    host_ce_n,
  output pstate_t st_q,
  output pstate_t st_nxt,
  output logic    fault_q
);
  localparam int unsigned CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_NORMAL:  if (!wp_f) st_nxt = ST_PROTECT;
      ST_PROTECT: begin
        if (!sw_f)     st_nxt = ST_BACKUP;
        else if (ok_f) st_nxt = ST_RECOVER;
      end
      ST_BACKUP:  if (sw_f) st_nxt = ST_PROTECT;
      ST_RECOVER: begin
        if (!wp_f)                     st_nxt = ST_PROTECT;
        else if (ok_f && cnt_q == LAST) st_nxt = ST_NORMAL;
      end
      default:    st_nxt = ST_BACKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_BACKUP;
    else     st_q <= st_nxt;
  end

  // Hold-off counter: cleared outside RECOVER and on any sag below full level.
  always_ff @(posedge clk) begin
    if (rst || (st_q != ST_RECOVER) || !ok_f) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
    end else if ((st_q == ST_NORMAL) && (st_nxt == ST_PROTECT) && !host_ce_n) begin
      fault_q <= 1'b1;
    end else if ((st_q != ST_NORMAL) && (st_nxt == ST_NORMAL)) begin
      fault_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_guard_gate.sv
module pwr_guard_gate
  import pwr_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pstate_t st_nxt,
  input  logic    host_ce_n,
  input  logic    host_we_n,
  input  logic    host_oe_n,
  output logic    mem_ce_n,
  output logic    mem_we_n,
  output logic    mem_oe_n,
  output logic    bus_en,
  output logic    sel_backup
);
  logic open_nxt;
  assign open_nxt = (st_nxt == ST_NORMAL);

  // Registered from the next state so the lock lands on the same edge as the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      bus_en     <= 1'b0;
      sel_backup <= 1'b1;
    end else begin
      mem_ce_n   <= host_ce_n | ~open_nxt;
      mem_we_n   <= host_we_n | ~open_nxt;
      mem_oe_n   <= host_oe_n | ~open_nxt;
      bus_en     <= open_nxt & ~host_ce_n & ~host_oe_n & host_we_n;
      sel_backup <= (st_nxt == ST_BACKUP);
    end
  end
endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int unsigned CODE_W     = 10,
  parameter int unsigned OK_LVL     = 450,
  parameter int unsigned WP_LVL     = 425,
  parameter int unsigned SW_LVL     = 300,
  parameter int unsigned HYST       = 4,
  parameter int unsigned REC_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vcode,
  input  logic              host_ce_n,
  input  logic              host_we_n,
  input  logic              host_oe_n,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              bus_en,
  output logic              sel_backup,
  output logic [1:0]        pwr_state,
  output logic              ce_fault
);
  localparam int unsigned LEVELS [N_LEVELS] = '{OK_LVL, WP_LVL, SW_LVL};

  logic [N_LEVELS-1:0] lvl_f;
  pstate_t st_q, st_nxt;

  for (genvar gi = 0; gi < N_LEVELS; gi++) begin : g_lvl
    pwr_guard_level #(
      .CODE_W(CODE_W),
      .LVL   (LEVELS[gi]),
      .HYST  (HYST)
    ) u_lvl (
      .clk  (clk),
      .rst  (rst),
      .code (vcode),
      .above(lvl_f[gi])
    );
  end

  pwr_guard_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ok_f     (lvl_f[IDX_OK]),
    .wp_f     (lvl_f[IDX_WP]),
    .sw_f     (lvl_f[IDX_SW]),
    .host_ce_n(host_ce_n),
    .st_q     (st_q),
    .st_nxt   (st_nxt),
    .fault_q  (ce_fault)
  );

  pwr_guard_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .st_nxt    (st_nxt),
    .host_ce_n (host_ce_n),
    .host_we_n (host_we_n),
    .host_oe_n (host_oe_n),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .bus_en    (bus_en),
    .sel_backup(sel_backup)
  );

  assign pwr_state = st_q;
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_ce_n,
  input logic       host_we_n,
  input logic       host_oe_n,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       mem_oe_n,
  input logic       bus_en,
  input logic       sel_backup,
  input logic [1:0] pwr_state,
  input logic       ce_fault
);
  localparam logic [1:0] S_NORMAL  = 2'd0;
  localparam logic [1:0] S_PROTECT = 2'd1;
  localparam logic [1:0] S_BACKUP  = 2'd2;
  localparam logic [1:0] S_RECOVER = 2'd3;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pwr_state == S_BACKUP) && sel_backup && mem_we_n && !bus_en && !ce_fault);

  p_follow_host_r2: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == S_NORMAL) |-> (mem_we_n == $past(host_we_n)) &&
                                (mem_ce_n == $past(host_ce_n)) &&
                                (mem_oe_n == $past(host_oe_n)));

  p_leave_normal_r4: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == S_NORMAL) |=> (pwr_state == S_NORMAL) || (pwr_state == S_PROTECT));

  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (pwr_state != S_NORMAL) |-> mem_ce_n && mem_we_n && mem_oe_n && !bus_en);

  p_backup_rail_r6: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == S_BACKUP) |-> sel_backup);

  p_enter_normal_r7: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state == S_NORMAL) && ($past(pwr_state) != S_NORMAL)) |-> ($past(pwr_state) == S_RECOVER));

  p_fault_raise_r10: assert property (@(posedge clk) disable iff (rst)
    (($past(pwr_state) == S_NORMAL) && (pwr_state == S_PROTECT) && !$past(host_ce_n)) |-> ce_fault);
endmodule

bind pwr_guard pwr_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_ce_n (host_ce_n),
  .host_we_n (host_we_n),
  .host_oe_n (host_oe_n),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .bus_en    (bus_en),
  .sel_backup(sel_backup),
  .pwr_state (pwr_state),
  .ce_fault  (ce_fault)
);

// File: tb/sim_pwr_guard.sv
module sim_pwr_guard;
  localparam int unsigned CW  = 10;
  localparam int unsigned REC = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] vcode = '0;
  logic          host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
  logic          mem_ce_n, mem_we_n, mem_oe_n, bus_en, sel_backup, ce_fault;
  logic [1:0]    pwr_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_guard #(
    .CODE_W(CW), .OK_LVL(450), .WP_LVL(425), .SW_LVL(300), .HYST(4), .REC_CYCLES(REC)
  ) u0 (
    .clk(clk), .rst(rst), .vcode(vcode),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .bus_en(bus_en), .sel_backup(sel_backup), .pwr_state(pwr_state), .ce_fault(ce_fault)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic host(input logic ce, input logic we, input logic oe);
    host_ce_n = ce; host_we_n = we; host_oe_n = oe;
  endtask

  task automatic t_reset;
    rst = 1'b1; vcode = '0; host(1, 1, 1);
    cyc(3);
    chk_eq("R1 state", pwr_state, 2);
    chk_eq("R1 sel_backup", sel_backup, 1);
    chk_eq("R1 enables", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk_eq("R1 bus_en", bus_en, 0);
    chk_eq("R1 fault", ce_fault, 0);
    rst = 1'b0;
    cyc(2);
    chk_eq("R1 state after release", pwr_state, 2);
  endtask

  task automatic t_powerup;
    vcode = 10'd460;
    cyc(2);
    chk_eq("R6 back to PROTECT", pwr_state, 1);
    chk_eq("R6 main rail", sel_backup, 0);
    cyc(1);
    chk_eq("R7 RECOVER entered", pwr_state, 3);
    host(0, 0, 0);
    cyc(63);
    chk_eq("R7 still RECOVER at hold-off end", pwr_state, 3);
    chk_eq("R5 controls ignored in RECOVER", {mem_ce_n, mem_we_n, mem_oe_n, bus_en}, 4'b1110);
    host(1, 1, 1);
    cyc(1);
    chk_eq("R7 NORMAL after hold-off", pwr_state, 0);
  endtask

  task automatic t_normal_pass;
    host(0, 1, 0); cyc(1);
    chk_eq("R2 read enables", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b010);
    chk_eq("R2 read drives bus", bus_en, 1);
    host(0, 0, 1); cyc(1);
    chk_eq("R2 write enables", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b001);
    chk_eq("R2 write no drive", bus_en, 0);
    host(1, 1, 0); cyc(1);
    chk_eq("R2 deselected no drive", {mem_ce_n, bus_en}, 2'b10);
    vcode = 10'd430; cyc(4);
    chk_eq("R3 band keeps NORMAL", pwr_state, 0);
  endtask

  task automatic t_abort_fault;
    host(0, 0, 1);
    vcode = 10'd424;
    cyc(1);
    chk_eq("R4 still NORMAL one cycle", pwr_state, 0);
    chk_eq("R4 write passes before lock", mem_we_n, 0);
    cyc(1);
    chk_eq("R4 PROTECT", pwr_state, 1);
    chk_eq("R4 write aborted same cycle", mem_we_n, 1);
    chk_eq("R10 fault raised", ce_fault, 1);
    host(0, 1, 0); cyc(3);
    chk_eq("R5 ignored in PROTECT", {mem_ce_n, mem_we_n, mem_oe_n, bus_en}, 4'b1110);
    host(1, 1, 1);
  endtask

  task automatic t_backup_hyst;
    vcode = 10'd290; cyc(2);
    chk_eq("R6 BACKUP", pwr_state, 2);
    chk_eq("R6 backup rail", sel_backup, 1);
    chk_eq("R10 fault held", ce_fault, 1);
    host(0, 1, 0);
    vcode = 10'd302; cyc(4);
    chk_eq("R3 inside band stays BACKUP", pwr_state, 2);
    chk_eq("R5 ignored in BACKUP", {mem_ce_n, bus_en}, 2'b10);
    host(1, 1, 1);
    vcode = 10'd304; cyc(2);
    chk_eq("R3 band top leaves BACKUP", pwr_state, 1);
  endtask

  task automatic t_restart;
    vcode = 10'd460; cyc(2);
    chk_eq("R7 RECOVER again", pwr_state, 3);
    cyc(30);
    vcode = 10'd440; cyc(3);
    chk_eq("R8 shallow dip stays RECOVER", pwr_state, 3);
    vcode = 10'd460;
    cyc(64);
    chk_eq("R8 hold-off restarted", pwr_state, 3);
    cyc(1);
    chk_eq("R8 NORMAL after full restart", pwr_state, 0);
    chk_eq("R10 fault cleared on NORMAL", ce_fault, 0);
  endtask

  task automatic t_no_fault_and_fallback;
    host(1, 1, 1);
    vcode = 10'd420; cyc(2);
    chk_eq("R4 PROTECT with CE idle", pwr_state, 1);
    chk_eq("R10 no fault with CE idle", ce_fault, 0);
    vcode = 10'd460; cyc(2);
    chk_eq("R7 RECOVER", pwr_state, 3);
    cyc(10);
    vcode = 10'd420; cyc(2);
    chk_eq("R9 deep dip back to PROTECT", pwr_state, 1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_normal_pass();
    t_abort_fault();
    t_backup_hyst();
    t_restart();
    t_no_fault_and_fallback();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule